// File: doc/BRIEF.md
# Pad Overcurrent and Shock Guard

This block keeps one supply or I/O pad safe without help from software. It watches two streams of digitized samples: the current through the pad and the magnitude of the acceleration seen by the chip. Each stream has its own valid strobe. When either stream goes past its trip level, the block drives the pad enable low so the pad stops conducting. It brings the pad back once both streams have stayed quiet for long enough.

Each stream is compared against two levels: a trip level and a lower release level. Once a stream has tripped, it counts as quiet only when its samples fall strictly below the release level for a programmable run of consecutive valid samples. Samples that land between the two levels do not change the state, and they restart the run. Two saturating counters record how many times each stream has tripped. The block also flags a configuration error when a release level lies above its trip level, and it holds the pad off while that error lasts.

Top module: `pad_guard`

## Requirements
- R1: A valid current sample strictly greater than `cur_trip_lvl` sets `oc_active` and drops `pad_en` on the next clock edge. A sample equal to the trip level does not trip.
- R2: While tripped, a valid current sample from `cur_rest_lvl` up to `cur_trip_lvl` inclusive leaves `oc_active` set and restarts the run of quiet samples.
- R3: `oc_active` clears on the edge of the Nth consecutive valid current sample strictly below `cur_rest_lvl`, where N is `hold_len`. A `hold_len` of 0 acts as 1.
- R4: A valid acceleration sample strictly greater than `acc_trip_lvl` sets `shock_active` and drops `pad_en` on the next clock edge.
- R5: `shock_active` clears only after `hold_len` consecutive valid acceleration samples strictly below `acc_rest_lvl`. Samples from `acc_rest_lvl` up to `acc_trip_lvl` keep it set and restart the run.
- R6: `pad_en` is high only when `oc_active`, `shock_active` and `cfg_err` are all low.
- R7: A sample whose valid strobe is low has no effect. It neither trips a stream nor counts toward or breaks a quiet run.
- R8: `oc_count` and `shock_count` each add one on every 0-to-1 transition of their own flag. Each saturates at 2^CNT_W-1, which is 255 by default.
- R9: After reset, `pad_en` is high (given ordered levels), both flags are low and both counters are zero.
- R10: `cfg_err` is high, with no clock delay, whenever `cur_rest_lvl > cur_trip_lvl` or `acc_rest_lvl > acc_trip_lvl`. While it is high, `pad_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_valid | input | 1 | Current sample strobe |
| cur_sample | input | CUR_W | Pad current sample |
| acc_valid | input | 1 | Acceleration sample strobe |
| acc_sample | input | ACC_W | Acceleration magnitude sample |
| cur_trip_lvl | input | CUR_W | Current trip level |
| cur_rest_lvl | input | CUR_W | Current release level |
| acc_trip_lvl | input | ACC_W | Acceleration trip level |
| acc_rest_lvl | input | ACC_W | Acceleration release level |
| hold_len | input | HOLD_W | Number of quiet samples needed to release |
| pad_en | output | 1 | Pad enable |
| oc_active | output | 1 | Overcurrent condition held |
| shock_active | output | 1 | Shock condition held |
| cfg_err | output | 1 | Levels out of order |
| oc_count | output | CNT_W | Overcurrent trip count |
| shock_count | output | CNT_W | Shock trip count |

## Verification
A quiet-run counter that fails to clear would show up as a release that comes early. The pad would rise one or more samples after an in-band sample, when it should still be off. A flag that is stuck or set wrongly shows on `pad_en` one edge after the sample that should have changed it. A counter with a bad increment or a missing saturation shows at the count outputs right after the trip that caused it. The saturation case only appears after 255 trips. The checks therefore compare each output on the cycle after every driven sample, and they include runs of trips long enough to reach the counter limit.

// File: rtl/pad_guard.sv
module pad_guard #(
  parameter int CUR_W  = 12,
  parameter int ACC_W  = 12,
  parameter int HOLD_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_valid,
  input  logic [CUR_W-1:0]  cur_sample,
  input  logic              acc_valid,
  input  logic [ACC_W-1:0]  acc_sample,
  input  logic [CUR_W-1:0]  cur_trip_lvl,
  input  logic [CUR_W-1:0]  cur_rest_lvl,
  input  logic [ACC_W-1:0]  acc_trip_lvl,
  input  logic [ACC_W-1:0]  acc_rest_lvl,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              pad_en,
  output logic              oc_active,
  output logic              shock_active,
  output logic              cfg_err,
  output logic [CNT_W-1:0]  oc_count,
  output logic [CNT_W-1:0]  shock_count
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [HOLD_W-1:0] HOLD_MAX = {HOLD_W{1'b1}};

  logic [HOLD_W-1:0] oc_run, sh_run, oc_run_nx, sh_run_nx, hold_eff;

  assign hold_eff  = (hold_len == '0) ? HOLD_W'(1) : hold_len;
  assign oc_run_nx = (oc_run == HOLD_MAX) ? oc_run : oc_run + 1'b1;
  assign sh_run_nx = (sh_run == HOLD_MAX) ? sh_run : sh_run + 1'b1;
  assign cfg_err   = (cur_rest_lvl > cur_trip_lvl) || (acc_rest_lvl > acc_trip_lvl);
  assign pad_en    = !oc_active && !shock_active && !cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_active <= 1'b0;
      oc_run    <= '0;
      oc_count  <= '0;
    end else if (cur_valid) begin
      if (cur_sample > cur_trip_lvl) begin
        if (!oc_active && oc_count != CNT_MAX) oc_count <= oc_count + 1'b1;
        oc_active <= 1'b1;
        oc_run    <= '0;
      end else if (oc_active && cur_sample < cur_rest_lvl) begin
        if (oc_run_nx >= hold_eff) begin
          oc_active <= 1'b0;
          oc_run    <= '0;
        end else begin
          oc_run <= oc_run_nx;
        end
      end else begin
        oc_run <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shock_active <= 1'b0;
      sh_run       <= '0;
      shock_count  <= '0;
    end else if (acc_valid) begin
      if (acc_sample > acc_trip_lvl) begin
        if (!shock_active && shock_count != CNT_MAX) shock_count <= shock_count + 1'b1;
        shock_active <= 1'b1;
        sh_run       <= '0;
      end else if (shock_active && acc_sample < acc_rest_lvl) begin
        if (sh_run_nx >= hold_eff) begin
          shock_active <= 1'b0;
          sh_run       <= '0;
        end else begin
          sh_run <= sh_run_nx;
        end
      end else begin
        sh_run <= '0;
      end
    end
  end

  a_r1_cur_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && cur_sample > cur_trip_lvl) |=> (oc_active && !pad_en));

  a_r4_shock_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_sample > acc_trip_lvl) |=> (shock_active && !pad_en));

  a_r3_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_active) |-> ($past(cur_valid) && $past(cur_sample) < $past(cur_rest_lvl)));

  a_r5_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shock_active) |-> ($past(acc_valid) && $past(acc_sample) < $past(acc_rest_lvl)));

  a_r7_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |=> ($stable(oc_active) && $stable(oc_count)));

  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(shock_active) && $stable(shock_count)));

  a_r8_oc_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_active) |-> (oc_count == CNT_W'($past(oc_count) + 1'b1) || $past(oc_count) == CNT_MAX));

  a_r8_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_count == CNT_MAX) |=> (oc_count == CNT_MAX));

  a_r2_band_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_active && cur_valid && cur_sample >= cur_rest_lvl) |=> oc_active);
endmodule

// File: tb/pad_guard_bench.sv
module pad_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cur_valid = 1'b0, acc_valid = 1'b0;
  logic [11:0] cur_sample = '0, acc_sample = '0;
  logic [11:0] cur_trip_lvl = 12'd1000, cur_rest_lvl = 12'd800;
  logic [11:0] acc_trip_lvl = 12'd500,  acc_rest_lvl = 12'd300;
  logic [7:0]  hold_len = 8'd3;
  logic        pad_en, oc_active, shock_active, cfg_err;
  logic [7:0]  oc_count, shock_count;
  int checks = 0, fails = 0;
  int exp_oc = 0, exp_sh = 0;

  always #4 clk = ~clk;

  pad_guard u_pad_guard (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cur_smp(input int v, input bit vld = 1'b1);
    @(negedge clk); cur_valid = vld; cur_sample = 12'(v);
    @(negedge clk); cur_valid = 1'b0;
  endtask

  task automatic acc_smp(input int v);
    @(negedge clk); acc_valid = 1'b1; acc_sample = 12'(v);
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(pad_en == 1, "R9 pad_en", pad_en, 1);
    chk(!oc_active && !shock_active, "R9 flags", oc_active + shock_active, 0);
    chk(oc_count == 0 && shock_count == 0, "R9 counts", oc_count + shock_count, 0);
    chk(cfg_err == 0, "R9 cfg_err", cfg_err, 0);
  endtask

  task automatic t_cur_trip;
    cur_smp(1000);
    chk(pad_en == 1, "R1 equal no trip", pad_en, 1);
    cur_smp(1001);
    exp_oc++;
    chk(oc_active && !pad_en, "R1 trip", pad_en, 0);
    chk(oc_count == exp_oc, "R8 oc count", oc_count, exp_oc);
  endtask

  task automatic t_hyst_release;
    cur_smp(900);
    chk(oc_active == 1, "R2 band hold", oc_active, 1);
    cur_smp(799); cur_smp(799); cur_smp(800);
    chk(oc_active == 1, "R2 band restarts run", oc_active, 1);
    cur_smp(799); cur_smp(799);
    chk(oc_active == 1, "R3 two of three", oc_active, 1);
    cur_smp(3000, 1'b0);
    chk(oc_active == 1 && oc_count == exp_oc, "R7 invalid ignored", oc_count, exp_oc);
    cur_smp(799);
    chk(!oc_active && pad_en, "R3 release", pad_en, 1);
  endtask

  task automatic t_invalid;
    cur_smp(4000, 1'b0);
    chk(pad_en == 1 && oc_count == exp_oc, "R7 no trip", pad_en, 1);
  endtask

  task automatic t_shock;
    acc_smp(501);
    exp_sh++;
    chk(shock_active && !pad_en, "R4 shock trip", pad_en, 0);
    chk(shock_count == exp_sh && oc_count == exp_oc, "R8 shock count", shock_count, exp_sh);
    acc_smp(299); acc_smp(299); acc_smp(400);
    acc_smp(299); acc_smp(299);
    chk(shock_active == 1, "R5 band restarts run", shock_active, 1);
    acc_smp(299);
    chk(!shock_active && pad_en, "R5 release", pad_en, 1);
  endtask

  task automatic t_both;
    cur_smp(1500); acc_smp(900);
    exp_oc++; exp_sh++;
    repeat (3) cur_smp(10);
    chk(!oc_active && !pad_en, "R6 shock still holds pad", pad_en, 0);
    repeat (3) acc_smp(10);
    chk(pad_en == 1, "R6 both clear", pad_en, 1);
  endtask

  task automatic t_cfg;
    @(negedge clk); cur_rest_lvl = 12'd1100;
    #1 chk(cfg_err && !pad_en, "R10 cur order", pad_en, 0);
    cur_rest_lvl = 12'd800; acc_rest_lvl = 12'd600;
    #1 chk(cfg_err && !pad_en, "R10 acc order", pad_en, 0);
    acc_rest_lvl = 12'd300;
    #1 chk(!cfg_err && pad_en, "R10 cleared", pad_en, 1);
  endtask

  task automatic t_hold0;
    hold_len = 8'd0;
    cur_smp(2000); exp_oc++;
    cur_smp(0);
    chk(!oc_active && pad_en, "R3 hold zero acts as one", pad_en, 1);
  endtask

  task automatic t_sat;
    hold_len = 8'd1;
    for (int i = 0; i < 260; i++) begin
      cur_smp(2000); cur_smp(0);
      if (exp_oc < 255) exp_oc++;
    end
    chk(oc_count == 255 && exp_oc == 255, "R8 saturate", oc_count, 255);
    chk(shock_count == exp_sh, "R8 separate", shock_count, exp_sh);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cur_trip();
    t_hyst_release();
    t_invalid();
    t_shock();
    t_both();
    t_cfg();
    t_hold0();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule